// File: doc/BRIEF.md
# Source-Synchronous Transmit Capture FIFO

This block takes parallel transmit words that arrive with their own interface clock and hands them, one character-wide word per cycle, to the encoder stage that runs on the internal transmit clock. Each channel has its own interface clock that travels with its data. A select input makes channel 0's interface clock the capture clock for every channel, for systems that route one clock to all lanes. The two clock domains run at the same frequency with an unknown phase that may drift. A small Gray-pointer FIFO per channel absorbs that phase difference.

A mode input picks the capture scheme. In single-data-rate mode a full word is sampled on every rising edge of the capture clock. In double-data-rate mode only the lower half of each lane is used. A half-word is sampled on the rising edge and another on the following falling edge, and the two are packed into one word. The read side waits until two words are buffered before it begins to stream, so that it starts with a cushion against underflow. A per-channel sticky error flag reports a pointer collision in either direction.

Top module: `tx_capture_fifo`

## Requirements
- R1: While `rstN` is low, every bit of `wordValid` and `fifoErr` is 0.
- R2: With `ddrMode` = 0, each value present on a channel's lane slice `txData[c*W +: W]` at a rising edge of its capture clock after reset release appears on `wordOut[c*W +: W]` in the same order, with no word dropped, repeated or inserted.
- R3: With `ddrMode` = 1, lane bits [W/2-1:0] sampled at a rising edge form bits [W/2-1:0] of a word, and lane bits [W/2-1:0] sampled at the next falling edge form bits [W-1:W/2]. Lane bits [W-1:W/2] have no effect. Any half not yet sampled since reset release reads as zero.
- R4: With `shareClk` = 1, every channel is captured on `ifClk[0]`, and the other channels' `ifClk` inputs have no effect. Data still arrives when those clocks are stopped.
- R5: After reset release a channel's `wordValid` stays low for at least three `clk` rising edges. Streaming starts only once two words are buffered, and the first word delivered is the first word captured.
- R6: For any fixed phase between the capture clock and `clk` at equal frequency, once `wordValid` of a channel rises it stays high on every following `clk` cycle, and `fifoErr` stays 0.
- R7: If a channel's capture clock stops while it is streaming, its `fifoErr` goes high (underflow). It stays high after the clock resumes, until reset.
- R8: If `clk` stops while capture continues, the channel's `fifoErr` is high within a few cycles after `clk` resumes (overflow). It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal transmit clock, read side |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| ddrMode | input | 1 | 0: capture on rising edges; 1: capture half-words on both edges |
| shareClk | input | 1 | 1: channel 0's interface clock captures all channels |
| ifClk | input | NUM_CH | Per-channel source-synchronous interface clocks |
| txData | input | NUM_CH*W | Lane data, channel c in bits [c*W +: W] |
| wordOut | output | NUM_CH*W | Words toward the encoder, channel c in bits [c*W +: W] |
| wordValid | output | NUM_CH | Per-channel word strobe on `clk` |
| fifoErr | output | NUM_CH | Per-channel sticky overflow/underflow flag |

## Verification
The properties take for granted that every active capture clock runs at exactly the read clock's rate. Under that condition a started stream can only break when one of the clocks stops. The properties also assume reset is released away from every clock edge. The stimulus changes phases, modes and the clock-share select only while reset is held. It moves lane data a quarter period after each capture edge. It stops a clock only in the two error cases, and after those it applies reset before streaming resumes.

// File: rtl/txcap_pkg.sv
package txcap_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FIFO_DEPTH  = 16;
  localparam int ADDR_W      = $clog2(FIFO_DEPTH);
  localparam int PTR_W       = ADDR_W + 1;
  localparam int START_LEVEL = 2;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } fifo_strobe_t;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/txcap_ctrl.sv
module txcap_ctrl
  import txcap_pkg::*;
(
  input  logic         capClk,
  input  logic         clk,
  input  logic         rstN,
  output fifo_strobe_t strb,
  output logic         fifoErr
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [PTR_W-1:0] wrBin, wrGray, wrNext;
  logic [PTR_W-1:0] rdBin, rdGray, rdNext;
  logic [PTR_W-1:0] rdGrayS1, rdGrayS2, wrGrayS1, wrGrayS2;
  logic [PTR_W-1:0] wrLevel, rdLevel;
  logic wrFull, rdEmpty, running;
  logic ovfW, ovfS1, ovfS2, unfR;

  // write side: level as seen through the synchronized read pointer
  assign wrNext  = wrBin + 1'b1;
  assign wrLevel = wrBin - gray2bin(rdGrayS2);
  assign wrFull  = (wrLevel == PTR_W'(FIFO_DEPTH));

  always_ff @(posedge capClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
      ovfW     <= 1'b0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (!wrFull) begin
        wrBin  <= wrNext;
        wrGray <= bin2gray(wrNext);
      end else begin
        ovfW <= 1'b1;
      end
    end
  end

  // read side: level as seen through the synchronized write pointer
  assign rdNext  = rdBin + 1'b1;
  assign rdLevel = gray2bin(wrGrayS2) - rdBin;
  assign rdEmpty = (rdLevel == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
      running  <= 1'b0;
      unfR     <= 1'b0;
      ovfS1    <= 1'b0;
      ovfS2    <= 1'b0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      ovfS1    <= ovfW;
      ovfS2    <= ovfS1;
      if (!running && rdLevel >= PTR_W'(START_LEVEL)) running <= 1'b1;
      if (running && !rdEmpty) begin
        rdBin  <= rdNext;
        rdGray <= bin2gray(rdNext);
      end
      if (running && rdEmpty) unfR <= 1'b1;
    end
  end

  always_comb begin
    strb.wrEn   = !wrFull;
    strb.wrAddr = wrBin[ADDR_W-1:0];
    strb.rdEn   = running && !rdEmpty;
    strb.rdAddr = rdBin[ADDR_W-1:0];
  end

  assign fifoErr = unfR | ovfS2;
endmodule

// File: rtl/txcap_datapath.sv
module txcap_datapath
  import txcap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         capClk,
  input  logic         clk,
  input  logic         rstN,
  input  logic         ddrMode,
  input  logic [W-1:0] laneIn,
  input  fifo_strobe_t strb,
  output logic [W-1:0] wordOut,
  output logic         wordValid
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = W / 2;

  logic [HALF-1:0]   riseHalf;
  logic [W-HALF-1:0] fallHalf;
  logic [W-1:0]      capWord;
  logic [W-1:0]      mem [FIFO_DEPTH];

  always_ff @(posedge capClk or negedge rstN) begin
    if (!rstN) riseHalf <= '0;
    else       riseHalf <= laneIn[HALF-1:0];
  end

  always_ff @(negedge capClk or negedge rstN) begin
    if (!rstN) fallHalf <= '0;
    else       fallHalf <= laneIn[W-HALF-1:0];
  end

  // DDR: the pair completed by the falling edge is stored at the next rising edge
  assign capWord = ddrMode ? {fallHalf, riseHalf} : laneIn;

  always_ff @(posedge capClk) begin
    if (strb.wrEn) mem[strb.wrAddr] <= capWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strb.rdEn;
      if (strb.rdEn) wordOut <= mem[strb.rdAddr];
    end
  end
endmodule

// File: rtl/tx_capture_fifo.sv
module tx_capture_fifo
  import txcap_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ddrMode,
  input  logic                shareClk,
  input  logic [NUM_CH-1:0]   ifClk,
  input  logic [NUM_CH*W-1:0] txData,
  output logic [NUM_CH*W-1:0] wordOut,
  output logic [NUM_CH-1:0]   wordValid,
  output logic [NUM_CH-1:0]   fifoErr
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic         capClk;
    fifo_strobe_t strb;

    if (ch == 0) begin : g_own
      assign capClk = ifClk[0];
    end else begin : g_sel
      assign capClk = shareClk ? ifClk[0] : ifClk[ch];
    end

    txcap_ctrl u_ctrl (
      .capClk (capClk),
      .clk    (clk),
      .rstN   (rstN),
      .strb   (strb),
      .fifoErr(fifoErr[ch])
    );

    txcap_datapath #(.W(W)) u_dp (
      .capClk   (capClk),
      .clk      (clk),
      .rstN     (rstN),
      .ddrMode  (ddrMode),
      .laneIn   (txData[ch*W +: W]),
      .strb     (strb),
      .wordOut  (wordOut[ch*W +: W]),
      .wordValid(wordValid[ch])
    );
  end
endmodule

// File: rtl/tx_capture_fifo_chk.sv
module tx_capture_fifo_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] wordValid,
  input logic [NUM_CH-1:0] fifoErr
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (wordValid == '0 && fifoErr == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    // R5
    start_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(wordValid[i]) |-> sinceRst >= 3'd3);
    // R6
    stream_gapless_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wordValid[i] && !fifoErr[i]) |=> (wordValid[i] || fifoErr[i]));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      fifoErr[i] |=> fifoErr[i]);
  end
endmodule

bind tx_capture_fifo tx_capture_fifo_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wordValid(wordValid),
  .fifoErr  (fifoErr)
);

// File: tb/tx_capture_fifo_test.sv
module tx_capture_fifo_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NUM_CH = 2;
  localparam int W      = 8;
  localparam int HALF   = W / 2;
  typedef logic [W-1:0] word_t;

  logic clk = 1'b0, tick = 1'b0, rstN = 1'b1;
  logic ddrMode = 1'b0, shareClk = 1'b0;
  logic clkRun = 1'b1, cmpOn = 1'b0, done = 1'b0;
  logic [NUM_CH-1:0] chRun = '1;
  realtime sysPh = 0.2;
  realtime chPh [NUM_CH];
  logic [NUM_CH-1:0]   ifClk;
  logic [NUM_CH*W-1:0] txData;
  logic [NUM_CH*W-1:0] wordOut;
  logic [NUM_CH-1:0]   wordValid, fifoErr;
  int vectors = 0, miscompares = 0;
  int gotArr [NUM_CH];
  int vecArr [NUM_CH];
  int badArr [NUM_CH];

  tx_capture_fifo #(.NUM_CH(NUM_CH), .W(W)) uut (
    .clk(clk), .rstN(rstN), .ddrMode(ddrMode), .shareClk(shareClk),
    .ifClk(ifClk), .txData(txData), .wordOut(wordOut),
    .wordValid(wordValid), .fifoErr(fifoErr)
  );

  function automatic word_t expectWord(input logic ddr, input logic [HALF-1:0] riseH,
                                       input logic [W-HALF-1:0] fallH, input word_t full);
    return ddr ? {fallH, riseH} : full;
  endfunction

  initial forever #2.5 tick = ~tick;

  initial forever begin
    @(posedge tick);
    if (clkRun) begin #(sysPh); clk = 1'b1; #2.5; clk = 1'b0; end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bch
    logic  ifc = 1'b0;
    logic  capB;
    word_t laneV = '0;
    word_t q[$];
    logic [HALF-1:0]   riseM = '0;
    logic [W-HALF-1:0] fallM = '0;
    logic  seen = 1'b0;
    int    gotC = 0, vec = 0, bad = 0;

    assign ifClk[c]           = ifc;
    assign txData[c*W +: W]   = laneV;
    assign capB               = shareClk ? ifClk[0] : ifClk[c];   // R4 model
    assign gotArr[c]          = gotC;
    assign vecArr[c]          = vec;
    assign badArr[c]          = bad;

    initial forever begin
      @(posedge tick);
      if (chRun[c]) begin #(chPh[c]); ifc = 1'b1; #2.5; ifc = 1'b0; end
    end

    // lane data moves a quarter period after each capture edge
    initial forever begin
      @(capB);
      #1.25;
      laneV = word_t'($urandom);
    end

    // expected-word model (R2, R3)
    initial forever begin
      @(capB or negedge rstN);
      if (!rstN) begin
        q.delete(); riseM = '0; fallM = '0;
      end else if (capB) begin
        q.push_back(expectWord(ddrMode, riseM, fallM, laneV));
        riseM = laneV[HALF-1:0];
      end else begin
        fallM = laneV[W-HALF-1:0];
      end
    end

    initial forever begin
      word_t expW;
      @(negedge clk);
      if (!rstN) begin
        seen = 1'b0; gotC = 0;
      end else if (cmpOn) begin
        if (wordValid[c]) begin
          vec++; gotC++; seen = 1'b1;
          if (q.size() == 0) begin
            bad++;
            $display("FAIL R2 ch%0d: actual %h expected none", c, wordOut[c*W +: W]);
          end else begin
            expW = q.pop_front();
            if (wordOut[c*W +: W] !== expW) begin
              bad++;
              $display("FAIL %s ch%0d: actual %h expected %h",
                       ddrMode ? "R3" : "R2", c, wordOut[c*W +: W], expW);
            end
          end
        end else if (seen) begin
          vec++; bad++;
          $display("FAIL R6 ch%0d: wordValid actual 0 expected 1", c);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finishRun();
    int v, m;
    v = vectors; m = miscompares;
    for (int c = 0; c < NUM_CH; c++) begin v += vecArr[c]; m += badArr[c]; end
    $display("== %0d vectors applied, %0d miscompares ==", v, m);
    $finish;
  endtask

  task automatic runCase(input logic ddr, input logic share, input realtime p0,
                         input realtime p1, input realtime ps, input int cycles);
    int n;
    cmpOn = 1'b0; rstN = 1'b0;
    ddrMode = ddr; shareClk = share;
    chPh[0] = p0; chPh[1] = p1; sysPh = ps;
    chRun = share ? NUM_CH'(1) : '1; clkRun = 1'b1;
    repeat (4) @(posedge tick);
    #1;
    // R1
    check(wordValid == '0 && fifoErr == '0, "R1", {wordValid, fifoErr}, 0);
    @(posedge tick); #0.55;
    rstN = 1'b1; cmpOn = 1'b1;
    n = 0;
    while (!wordValid[0] && n < 40) begin @(posedge clk); #1; n++; end
    // R5: at least three read edges before the first word
    check(n >= 3 && n <= 12, "R5", n, 3);
    repeat (cycles) @(posedge clk);
    #1;
    // R6
    check(fifoErr == '0, "R6", fifoErr, 0);
    for (int c = 0; c < NUM_CH; c++)
      check(gotArr[c] >= cycles - 2, share ? "R4" : (ddr ? "R3" : "R2"), gotArr[c], cycles);
  endtask

  initial begin
    realtime phs [4];
    phs[0] = 0.2; phs[1] = 0.9; phs[2] = 1.6; phs[3] = 2.3;
    void'($urandom(32'd6021));
    chPh[0] = 0.2; chPh[1] = 0.2;
    #0.1 rstN = 1'b0;

    runCase(1'b0, 1'b0, 0.2, 1.6, 0.9, 300);   // R2
    runCase(1'b0, 1'b0, 2.3, 0.2, 0.2, 300);   // R6 capture near +180 deg
    runCase(1'b0, 1'b0, 0.2, 2.3, 2.3, 300);   // R6 capture near -180 deg
    runCase(1'b1, 1'b0, 1.6, 0.2, 0.9, 300);   // R3
    runCase(1'b1, 1'b0, 0.2, 0.9, 2.3, 300);   // R3
    runCase(1'b1, 1'b0, 2.3, 2.3, 0.2, 300);   // R3
    runCase(1'b0, 1'b1, 0.9, 0.2, 0.2, 300);   // R4
    runCase(1'b1, 1'b1, 2.3, 0.9, 1.6, 300);   // R4
    for (int k = 0; k < 4; k++)
      runCase(1'($urandom), 1'($urandom), phs[$urandom % 4], phs[$urandom % 4],
              phs[$urandom % 4], 250);

    // R7: stop capture clocks while streaming
    runCase(1'b0, 1'b0, 0.9, 1.6, 0.2, 100);
    cmpOn = 1'b0; chRun = '0;
    repeat (20) @(posedge clk);
    #1;
    check(fifoErr == '1, "R7", fifoErr, 3);
    chRun = '1;
    repeat (20) @(posedge clk);
    #1;
    check(fifoErr == '1, "R7", fifoErr, 3);

    // R8: stop the read clock while capture runs
    runCase(1'b1, 1'b0, 1.6, 0.9, 2.3, 100);
    cmpOn = 1'b0; clkRun = 1'b0;
    repeat (40) @(posedge tick);
    clkRun = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(fifoErr == '1, "R8", fifoErr, 3);
    repeat (10) @(posedge clk);
    #1;
    check(fifoErr == '1, "R8", fifoErr, 3);
    rstN = 1'b0;
    #3;
    // R1: reset clears the sticky flags at once
    check(wordValid == '0 && fifoErr == '0, "R1", {wordValid, fifoErr}, 0);

    done = 1'b1;
    finishRun();
  end

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule